// File: doc/BRIEF.md
# Multi-Echo Time-of-Flight Pixel Row

This block is a row of photon-timing pixels for a flash depth sensor. A single laser strobe opens a counting window for every pixel at once. Each pixel owns two 11-bit time slots, and each slot is its own counter: it counts reference-clock cycles from the strobe until the pixel sees a detector hit. The first hit freezes slot 0. A later hit freezes slot 1, provided it comes at least a set dead time after the first. A near, weak reflection therefore cannot mask a true target that lies further away. A slot that never sees a hit saturates at all ones, which means "no return".

When the window closes, the same slot flip-flops are re-used as one serial chain that carries every code out of the row. The counting phase and the shifting phase each have their own clock-enable gate, and only one of them is ever open. The block then raises a one-cycle completion flag and returns to idle, ready for the next laser strobe. Detector hits arrive asynchronously. Each one passes through a two-flop synchroniser, and only its rising edge counts.

Top module: `tofr_echo_row`

## Requirements
- R1: While reset is held and after its release, `sdata_o`, `sdata_vld_o`, `cnt_gate_o`, `shf_gate_o` and `done_o` are all 0 until a start strobe is seen.
- R2: Counting cycles are numbered from 1, starting with the cycle after the one in which `start_i` is sampled high in idle. If a pixel's hit input first rises during counting cycle n, slot 0 holds n+1 (synchroniser plus edge detect), limited to 2^CODE_W-1.
- R3: A later rising hit that comes g cycles after the first (g >= DEAD_CYC) freezes slot 1 with its own code, n+1. A rising hit with g < DEAD_CYC is dropped, and slot 1 stays free for a later hit.
- R4: Once both slots are frozen, further hits in the same window change neither code.
- R5: A slot that sees no accepted hit before the window ends reads 2^CODE_W-1 (all ones). A hit that comes after the slot has saturated also reads all ones.
- R6: Readout lasts exactly NUM_PIX*2*CODE_W cycles, with `sdata_vld_o` high for all of them. The order is pixel 0 first, and within a pixel slot 0 before slot 1, each code MSB first.
- R7: `cnt_gate_o` is high for exactly WIN_LEN cycles per frame. `shf_gate_o` is high for exactly NUM_PIX*2*CODE_W cycles. The two are never high together.
- R8: `done_o` is high for exactly one cycle, the cycle right after the last serial bit.
- R9: A start strobe during counting or readout has no effect. Hits seen in idle or during readout do not change any code or the serial stream.
- R10: A hit held high across many cycles is one event. It freezes slot 0 only, and slot 1 reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference counting clock |
| rst_n | input | 1 | Active-low asynchronous-style reset, sampled synchronously |
| start_i | input | 1 | Laser emission strobe, opens the counting window |
| hit_i | input | NUM_PIX | Per-pixel detector hit, asynchronous |
| sdata_o | output | 1 | Serial code stream, MSB first |
| sdata_vld_o | output | 1 | High while `sdata_o` carries a code bit |
| cnt_gate_o | output | 1 | Counting clock enable (open during the window) |
| shf_gate_o | output | 1 | Shift clock enable (open during readout) |
| done_o | output | 1 | One-cycle flag after the last shifted bit |

## Verification
The bench builds the row with NUM_PIX=3, CODE_W=11, DEAD_CYC=4 and WIN_LEN=2100. Because the window is longer than the 2047 code range, saturation and hits after saturation can both be reached within one frame. The small dead time lets one frame put accepted and rejected second hits side by side. Three pixels give a 66-bit stream that still covers both pixel-to-pixel and slot-to-slot chaining.

// File: rtl/tofr_pkg.sv
package tofr_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_COUNT = 2'd1,
      PH_SHIFT = 2'd2
   } phase_t;

   localparam int unsigned SLOTS_PER_PIX = 2;

endpackage

// File: rtl/tofr_hit_sync.sv
module tofr_hit_sync #(
   parameter int unsigned LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] raw_i,
   output logic [LANES-1:0] rise_o
);

   generate
      if (LANES < 1) begin : g_bad
         $error("tofr_hit_sync: LANES must be at least 1");
      end
   endgenerate

   genvar ln;
   generate
      for (ln = 0; ln < LANES; ln++) begin : g_lane
         logic meta_q, stab_q, prev_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               meta_q <= 1'b0;
               stab_q <= 1'b0;
               prev_q <= 1'b0;
            end else begin
               meta_q <= raw_i[ln];
               stab_q <= meta_q;
               prev_q <= stab_q;
            end
         end

         assign rise_o[ln] = stab_q & ~prev_q;

         // R10
         rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[ln] |=> !rise_o[ln]);
      end
   endgenerate

endmodule

// File: rtl/tofr_seq.sv
module tofr_seq
   import tofr_pkg::*;
#(
   parameter int unsigned WIN_LEN    = 2048,
   parameter int unsigned TOTAL_BITS = 88
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic arm_o,
   output logic cnt_gate_o,
   output logic shf_gate_o,
   output logic done_o
);

   localparam int unsigned WW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
   localparam int unsigned BW = (TOTAL_BITS > 1) ? $clog2(TOTAL_BITS) : 1;
   localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);
   localparam logic [BW-1:0] BIT_LAST = BW'(TOTAL_BITS - 1);

   generate
      if (WIN_LEN < 2) begin : g_bad_win
         $error("tofr_seq: WIN_LEN must be at least 2");
      end
      if (TOTAL_BITS < 2) begin : g_bad_bits
         $error("tofr_seq: TOTAL_BITS must be at least 2");
      end
   endgenerate

   phase_t        ph_q;
   logic [WW-1:0] win_q;
   logic [BW-1:0] bit_q;
   logic          done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         win_q  <= '0;
         bit_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (ph_q)
            PH_IDLE: begin
               if (start_i) begin
                  ph_q  <= PH_COUNT;
                  win_q <= '0;
               end
            end
            PH_COUNT: begin
               if (win_q == WIN_LAST) begin
                  ph_q  <= PH_SHIFT;
                  bit_q <= '0;
               end else begin
                  win_q <= win_q + 1'b1;
               end
            end
            PH_SHIFT: begin
               if (bit_q == BIT_LAST) begin
                  ph_q   <= PH_IDLE;
                  done_q <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign arm_o      = (ph_q == PH_IDLE) && start_i;
   assign cnt_gate_o = (ph_q == PH_COUNT);
   assign shf_gate_o = (ph_q == PH_SHIFT);
   assign done_o     = done_q;

   // R7
   gates_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cnt_gate_o && shf_gate_o));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(shf_gate_o));

   // R9
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_gate_o && start_i && win_q != WIN_LAST) |=> cnt_gate_o && $stable(ph_q));

   // R7
   shift_from_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shf_gate_o) |-> $past(cnt_gate_o));

endmodule

// File: rtl/tofr_pixel.sv
module tofr_pixel
   import tofr_pkg::*;
#(
   parameter int unsigned CODE_W   = 11,
   parameter int unsigned DEAD_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic cnt_en_i,
   input  logic shf_en_i,
   input  logic hit_i,
   input  logic sin_i,
   output logic sout_o
);

   localparam int unsigned DW = $clog2(DEAD_CYC + 1);
   localparam logic [CODE_W-1:0] CODE_MAX = '1;
   localparam logic [DW-1:0]     DEAD_LIM = DW'(DEAD_CYC);
   localparam int unsigned       NS = SLOTS_PER_PIX;

   generate
      if (CODE_W < 2) begin : g_bad_w
         $error("tofr_pixel: CODE_W must be at least 2");
      end
      if (DEAD_CYC < 2) begin : g_bad_dead
         $error("tofr_pixel: DEAD_CYC must be at least 2");
      end
   endgenerate

   logic [CODE_W-1:0] slot_q [NS];
   logic              frz_q  [NS];
   logic              take   [NS];
   logic              shin   [NS];
   logic [DW-1:0]     dcnt_q;

   always_comb begin
      take[0] = 1'b1;
      take[1] = frz_q[0] && (dcnt_q >= DEAD_LIM);
      shin[0] = slot_q[1][CODE_W-1];
      shin[1] = sin_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || arm_i) begin
         for (int s = 0; s < NS; s++) begin
            slot_q[s] <= '0;
            frz_q[s]  <= 1'b0;
         end
      end else if (cnt_en_i) begin
         for (int s = 0; s < NS; s++) begin
            if (!frz_q[s]) begin
               if (hit_i && take[s]) begin
                  frz_q[s] <= 1'b1;
               end else if (slot_q[s] != CODE_MAX) begin
                  slot_q[s] <= slot_q[s] + 1'b1;
               end
            end
         end
      end else if (shf_en_i) begin
         for (int s = 0; s < NS; s++) begin
            slot_q[s] <= {slot_q[s][CODE_W-2:0], shin[s]};
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || arm_i) begin
         dcnt_q <= '0;
      end else if (cnt_en_i) begin
         if (!frz_q[0] && hit_i) begin
            dcnt_q <= DW'(1);
         end else if (frz_q[0] && dcnt_q != DEAD_LIM) begin
            dcnt_q <= dcnt_q + 1'b1;
         end
      end
   end

   assign sout_o = slot_q[0][CODE_W-1];

   // R4
   slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frz_q[1] |-> frz_q[0]);

   // R3
   second_needs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frz_q[1]) |-> $past(frz_q[0]));

   // R2
   held_code0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_q[0] && cnt_en_i) |=> $stable(slot_q[0]));

   // R4
   held_code1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_q[1] && cnt_en_i) |=> $stable(slot_q[1]));

endmodule

// File: rtl/tofr_echo_row.sv
module tofr_echo_row
   import tofr_pkg::*;
#(
   parameter int unsigned NUM_PIX  = 4,
   parameter int unsigned CODE_W   = 11,
   parameter int unsigned WIN_LEN  = 2048,
   parameter int unsigned DEAD_CYC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [NUM_PIX-1:0] hit_i,
   output logic               sdata_o,
   output logic               sdata_vld_o,
   output logic               cnt_gate_o,
   output logic               shf_gate_o,
   output logic               done_o
);

   localparam int unsigned TOTAL_BITS = NUM_PIX * SLOTS_PER_PIX * CODE_W;

   generate
      if (NUM_PIX < 1) begin : g_bad_pix
         $error("tofr_echo_row: NUM_PIX must be at least 1");
      end
   endgenerate

   logic               arm;
   logic               cnt_gate, shf_gate;
   logic [NUM_PIX-1:0] hit_rise;
   logic [NUM_PIX:0]   link;

   tofr_seq #(
      .WIN_LEN    (WIN_LEN),
      .TOTAL_BITS (TOTAL_BITS)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .arm_o      (arm),
      .cnt_gate_o (cnt_gate),
      .shf_gate_o (shf_gate),
      .done_o     (done_o)
   );

   tofr_hit_sync #(
      .LANES (NUM_PIX)
   ) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (hit_i),
      .rise_o (hit_rise)
   );

   assign link[NUM_PIX] = 1'b0;

   genvar px;
   generate
      for (px = 0; px < NUM_PIX; px++) begin : g_pix
         tofr_pixel #(
            .CODE_W   (CODE_W),
            .DEAD_CYC (DEAD_CYC)
         ) i_pix (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm_i    (arm),
            .cnt_en_i (cnt_gate),
            .shf_en_i (shf_gate),
            .hit_i    (hit_rise[px]),
            .sin_i    (link[px+1]),
            .sout_o   (link[px])
         );
      end
   endgenerate

   assign sdata_o     = link[0];
   assign sdata_vld_o = shf_gate;
   assign cnt_gate_o  = cnt_gate;
   assign shf_gate_o  = shf_gate;

   // R6
   vld_is_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdata_vld_o |-> !cnt_gate_o);

endmodule

// File: tb/test_tofr_echo_row.sv
module test_tofr_echo_row;

   localparam int NP   = 3;
   localparam int CW   = 11;
   localparam int WL   = 2100;
   localparam int DC   = 4;
   localparam int TOT  = NP * 2 * CW;
   localparam int MAXC = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [NP-1:0] hit = '0;
   logic          sdata, vld, cgate, sgate, done;

   int n_cmp = 0;
   int n_bad = 0;
   int cg_tot = 0, sg_tot = 0, ovl_tot = 0;
   int sched [NP][4];
   int exp_c [NP][2];

   always #2 clk = ~clk;

   tofr_echo_row #(
      .NUM_PIX  (NP),
      .CODE_W   (CW),
      .WIN_LEN  (WL),
      .DEAD_CYC (DC)
   ) i_tofr_echo_row (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .hit_i       (hit),
      .sdata_o     (sdata),
      .sdata_vld_o (vld),
      .cnt_gate_o  (cgate),
      .shf_gate_o  (sgate),
      .done_o      (done)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         cg_tot  <= cg_tot + int'(cgate);
         sg_tot  <= sg_tot + int'(sgate);
         ovl_tot <= ovl_tot + int'(cgate & sgate);
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic clear_sched();
      for (int p = 0; p < NP; p++)
         for (int k = 0; k < 4; k++) sched[p][k] = 0;
   endtask

   function automatic int cap(input int v);
      return (v > MAXC) ? MAXC : v;
   endfunction

   task automatic build_exp();
      for (int p = 0; p < NP; p++) begin
         int t0;
         bit h0, h1;
         h0 = 0; h1 = 0; t0 = 0;
         exp_c[p][0] = MAXC;
         exp_c[p][1] = MAXC;
         for (int k = 0; k < 4; k++) begin
            int n;
            n = sched[p][k];
            if (n != 0) begin
               if (!h0) begin
                  exp_c[p][0] = cap(n + 1); t0 = n; h0 = 1;
               end else if (!h1 && (n - t0) >= DC) begin
                  exp_c[p][1] = cap(n + 1); h1 = 1;
               end
            end
         end
      end
   endtask

   task automatic run_count(input int restart_at, input int hold_pix,
                            input int hold_from, input int hold_to);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (int n = 1; n <= WL; n++) begin
         logic [NP-1:0] h;
         h = '0;
         for (int p = 0; p < NP; p++)
            for (int k = 0; k < 4; k++)
               if (sched[p][k] == n) h[p] = 1'b1;
         if (hold_pix >= 0 && n >= hold_from && n <= hold_to) h[hold_pix] = 1'b1;
         hit   = h;
         start = (n == restart_at);
         @(negedge clk);
      end
      hit   = '0;
      start = 1'b0;
   endtask

   task automatic read_check(input string tag, input bit poke);
      logic [CW-1:0] got [NP][2];
      int vld_miss;
      vld_miss = 0;
      for (int i = 0; i < TOT; i++) begin
         int p, s, b;
         p = i / (2 * CW);
         s = (i / CW) % 2;
         b = CW - 1 - (i % CW);
         if (!vld) vld_miss++;
         got[p][s][b] = sdata;
         if (poke) hit = (i % 4 == 1) ? '1 : '0;
         @(negedge clk);
      end
      hit = '0;
      // R6: valid held for the whole stream, then dropped
      chk({tag, " R6 vld gaps"}, vld_miss, 0);
      chk({tag, " R6 vld after stream"}, vld, 0);
      // R8
      chk({tag, " R8 done after last bit"}, done, 1);
      for (int p = 0; p < NP; p++) begin
         chk($sformatf("%s R2 R6 pix%0d slot0", tag, p), got[p][0], exp_c[p][0]);
         chk($sformatf("%s R3 R6 pix%0d slot1", tag, p), got[p][1], exp_c[p][1]);
      end
      @(negedge clk);
      chk({tag, " R8 done width"}, done, 0);
   endtask

   task automatic frame(input string tag, input int restart_at, input bit poke,
                        input int hold_pix, input int hold_from, input int hold_to);
      int cg0, sg0, ov0;
      cg0 = cg_tot; sg0 = sg_tot; ov0 = ovl_tot;
      run_count(restart_at, hold_pix, hold_from, hold_to);
      read_check(tag, poke);
      // R7
      chk({tag, " R7 count gate cycles"}, cg_tot - cg0, WL);
      chk({tag, " R7 shift gate cycles"}, sg_tot - sg0, TOT);
      chk({tag, " R7 gate overlap"}, ovl_tot - ov0, 0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      // R1
      chk("R1 sdata in reset", sdata, 0);
      chk("R1 vld in reset", vld, 0);
      chk("R1 gates in reset", {cgate, sgate}, 0);
      @(negedge clk) rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 done after reset", done, 0);
      chk("R1 count gate idle", cgate, 0);
      chk("R1 shift gate idle", sgate, 0);
   endtask

   task automatic t_single_double();
      clear_sched();
      sched[0][0] = 10;
      sched[1][0] = 20; sched[1][1] = 24;
      build_exp();
      chk("R2 model slot0 pix0", exp_c[0][0], 11);
      frame("basic", -1, 0, -1, 0, 0);
   endtask

   task automatic t_dead_and_third();
      clear_sched();
      sched[0][0] = 30; sched[0][1] = 33; sched[0][2] = 40;
      sched[1][0] = 5;  sched[1][1] = 9;  sched[1][2] = 15; sched[1][3] = 25;
      sched[2][0] = 100; sched[2][1] = 103;
      build_exp();
      // R3 rejected gap 3 then accepted; R4 third and fourth hits dropped
      frame("deadtime R4", -1, 0, -1, 0, 0);
   endtask

   task automatic t_held();
      clear_sched();
      sched[1][0] = 70;
      build_exp();
      exp_c[0][0] = 51;
      exp_c[0][1] = MAXC;
      // R10
      frame("held R10", -1, 0, 0, 50, 60);
   endtask

   task automatic t_ignored();
      clear_sched();
      @(negedge clk) hit = 3'b010;
      @(negedge clk) hit = '0;
      repeat (6) @(negedge clk);
      sched[2][0] = 300;
      build_exp();
      // R9: idle hit, restart strobe, hits during readout
      frame("ignored R9", 500, 1, -1, 0, 0);
   endtask

   task automatic t_saturation();
      clear_sched();
      sched[0][0] = 2040; sched[0][1] = 2050;
      sched[1][0] = 2046;
      sched[2][0] = 2060;
      build_exp();
      // R5
      chk("R5 model late code", exp_c[2][0], MAXC);
      frame("saturate R5", -1, 0, -1, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_single_double();
      t_dead_and_third();
      t_held();
      t_ignored();
      t_saturation();
      finish_run();
   end

endmodule